// File: doc/BRIEF.md
# Shared Reservation Station Dispatcher

This block sits between the reorder buffer and the execution units of a dynamically scheduled core. It keeps a small pool of stations that every unit draws from: one integer unit, two floating-point adders, one floating-point multiplier and one floating-point divider. Each cycle the reorder-buffer side presents up to four candidate instructions. A candidate may name operands that are still in flight, by the tag of the entry that produces them. The block takes at most two candidates whose operands are complete, oldest first, and copies opcode, operand values and reorder position into free stations. A station stays occupied only until a matching unit accepts its instruction.

The block also tracks whether each unit is occupied. The integer unit, the adders and the multiplier accept a new operation every cycle unless a finished result is stuck at their output. The divider takes one operation at a time. A finished result stays in its unit until that unit wins the single result bus. When several results compete, the oldest reorder position wins. The result bus broadcast itself (tag and value) comes back in as an input and wakes up waiting candidates in the same cycle. The arithmetic is done elsewhere. The block only hands out operands and grants.

Top module: `rs_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, no station is occupied, no unit is issued to or reported busy, and no bus grant is given.
- R2: A candidate is taken only when each of its operands is either not pending or pending with a tag equal to `busTag` while `busValid` is high. In that second case the station stores `busValue` in place of the candidate's own value.
- R3: At most two candidates are taken per cycle, and never more than the number of stations that are free at the start of that cycle. A taken candidate goes into the lowest-numbered free station.
- R4: Age is (rob position minus `robHead`) modulo 8. When more candidates are ready than can be taken, those with the smallest age are taken.
- R5: An instruction taken in cycle t is offered to its unit from cycle t+1 on `issueValid`, carrying its operands and rob position. Its station is freed at the end of the cycle in which it issues.
- R6: Unit index 0 is integer, 1 and 2 are adders, 3 is the multiplier and 4 is the divider. Class codes are 0 integer, 1 add, 2 multiply and 3 divide. When two add stations are waiting and both adders are free, both issue in the same cycle, the older one to adder 1.
- R7: A result asks for the bus L cycles after its issue cycle, with L = 2, 4, 6 and 10 for integer, add, multiply and divide. Pipelined units show `unitBusy` low while holding work that is still in flight.
- R8: The divider shows `unitBusy` from the cycle after it issues until its result is granted, and accepts no issue during that time.
- R9: Only one grant is given per cycle, to the oldest waiting result. A unit that loses holds its result and shows `unitBusy` until it is granted.
- R10: A station whose unit cannot accept stays occupied and keeps its instruction until a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| robHead | input | 3 | Rob position of the oldest instruction in flight |
| candValid | input | 4 | Candidate present, per slot |
| candCls | input | 4x2 | Unit class of each candidate |
| candFn | input | 4x4 | Function code passed through to the unit |
| candRob | input | 4x3 | Rob position of each candidate |
| candJPend | input | 4 | First operand still pending |
| candJTag | input | 4x3 | Producer tag of the first operand |
| candJVal | input | 4x16 | First operand value |
| candKPend | input | 4 | Second operand still pending |
| candKTag | input | 4x3 | Producer tag of the second operand |
| candKVal | input | 4x16 | Second operand value |
| busValid | input | 1 | Result bus carries a result this cycle |
| busTag | input | 3 | Rob position of the result on the bus |
| busValue | input | 16 | Value on the result bus |
| candTake | output | 4 | Candidate accepted this cycle, per slot |
| rsBusy | output | 4 | Station occupied, per station |
| issueValid | output | 5 | Operation issued to each unit this cycle |
| issueFn | output | 5x4 | Function code per unit |
| issueJ | output | 5x16 | First operand per unit |
| issueK | output | 5x16 | Second operand per unit |
| issueRob | output | 5x3 | Rob position per unit |
| unitBusy | output | 5 | Unit cannot accept an issue this cycle |
| grantValid | output | 1 | A result is granted the bus |
| grantUnit | output | 3 | Index of the granted unit |
| grantRob | output | 3 | Rob position of the granted result |

## Verification
The checker assumes that the rob positions of live instructions are distinct within one window of eight, so that ages are unique. It also assumes that candidates stay away from ones already taken. The bench never presents a rob position that is still held in a station or a unit. It lowers `candValid` right after each accepted cycle. The broadcast bus is driven only in the cycles a test chooses, independent of the block's own grants, so that a wakeup can be placed on a chosen cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;

  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;
  localparam int IDX_W     = 4;
  localparam int UNIT_INT  = 0;
  localparam int UNIT_DIV  = 4;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } opClsE;

  typedef struct packed {
    logic [1:0]                        allocEn;
    logic [1:0][IDX_W-1:0]             allocRs;
    logic [1:0][IDX_W-1:0]             allocCand;
    logic [1:0]                        capJ;
    logic [1:0]                        capK;
    logic [NUM_UNITS-1:0]              issueEn;
    logic [NUM_UNITS-1:0][IDX_W-1:0]   issueRs;
  } rsStrobeT;

  function automatic logic [1:0] unitClass(input int u);
    case (u)
      0:       return CLS_INT;
      1, 2:    return CLS_ADD;
      3:       return CLS_MUL;
      default: return CLS_DIV;
    endcase
  endfunction

endpackage

// File: rtl/rs_unit.sv
module rs_unit #(
  parameter int LAT   = 2,
  parameter bit PIPED = 1'b1,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [TAG_W-1:0] issueRob,
  input  logic             grant,
  output logic             accept,
  output logic             resValid,
  output logic [TAG_W-1:0] resRob
);

  logic [LAT-1:0]            stV;
  logic [LAT-1:0][TAG_W-1:0] stRob;
  logic                      stall;

  assign resValid = stV[LAT-1];
  assign resRob   = stRob[LAT-1];
  assign stall    = stV[LAT-1] & ~grant;

  generate
    if (PIPED) begin : g_piped
      assign accept = ~stall;
    end else begin : g_single
      assign accept = ~|stV;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stV   <= '0;
      stRob <= '0;
    end else if (!stall) begin
      stV      <= {stV[LAT-2:0], issue};
      stRob[0] <= issueRob;
      for (int i = 1; i < LAT; i++) stRob[i] <= stRob[i-1];
    end
  end

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int NUM_RS   = 4,
  parameter int TAG_W    = 3
) (
  input  logic [TAG_W-1:0]                    robHead,
  input  logic [NUM_CAND-1:0]                 candValid,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candRob,
  input  logic [NUM_CAND-1:0]                 candJPend,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candJTag,
  input  logic [NUM_CAND-1:0]                 candKPend,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candKTag,
  input  logic                                busValid,
  input  logic [TAG_W-1:0]                    busTag,
  input  logic [NUM_RS-1:0]                   rsBusy,
  input  logic [NUM_RS-1:0][1:0]              rsCls,
  input  logic [NUM_RS-1:0][TAG_W-1:0]        rsRob,
  input  logic [NUM_UNITS-1:0]                unitAccept,
  input  logic [NUM_UNITS-1:0]                unitResValid,
  input  logic [NUM_UNITS-1:0][TAG_W-1:0]     unitResRob,
  output rsStrobeT                            strobe,
  output logic [NUM_CAND-1:0]                 candTake,
  output logic [NUM_UNITS-1:0]                unitGrant,
  output logic                                grantValid,
  output logic [UNIT_W-1:0]                   grantUnit,
  output logic [TAG_W-1:0]                    grantRob
);

  logic [NUM_CAND-1:0]             jHit, kHit, candReady;
  logic [NUM_CAND-1:0][TAG_W-1:0]  candAge;
  logic [NUM_RS-1:0][TAG_W-1:0]    rsAge;

  always_comb begin
    for (int c = 0; c < NUM_CAND; c++) begin
      jHit[c]      = busValid && (candJTag[c] == busTag);
      kHit[c]      = busValid && (candKTag[c] == busTag);
      candReady[c] = candValid[c] && (!candJPend[c] || jHit[c]) && (!candKPend[c] || kHit[c]);
      candAge[c]   = candRob[c] - robHead;
    end
    for (int r = 0; r < NUM_RS; r++) rsAge[r] = rsRob[r] - robHead;
  end

  // oldest two ready candidates, lowest two free stations
  logic                 pick0Ok, pick1Ok, free0Ok, free1Ok;
  logic [IDX_W-1:0]     pick0, pick1, free0, free1;

  always_comb begin
    pick0Ok = 1'b0; pick0 = '0;
    for (int c = 0; c < NUM_CAND; c++)
      if (candReady[c] && (!pick0Ok || candAge[c] < candAge[pick0])) begin
        pick0Ok = 1'b1; pick0 = IDX_W'(c);
      end
    pick1Ok = 1'b0; pick1 = '0;
    for (int c = 0; c < NUM_CAND; c++)
      if (candReady[c] && !(pick0Ok && pick0 == IDX_W'(c)) &&
          (!pick1Ok || candAge[c] < candAge[pick1])) begin
        pick1Ok = 1'b1; pick1 = IDX_W'(c);
      end
    free0Ok = 1'b0; free0 = '0;
    free1Ok = 1'b0; free1 = '0;
    for (int r = 0; r < NUM_RS; r++)
      if (!rsBusy[r]) begin
        if (!free0Ok) begin
          free0Ok = 1'b1; free0 = IDX_W'(r);
        end else if (!free1Ok) begin
          free1Ok = 1'b1; free1 = IDX_W'(r);
        end
      end
  end

  // station -> unit selection, oldest matching station per unit
  logic [NUM_RS-1:0] taken;
  logic              found;
  logic [IDX_W-1:0]  best;
  logic [TAG_W-1:0]  bestAge;

  always_comb begin
    strobe              = '0;
    strobe.allocEn[0]   = pick0Ok && free0Ok;
    strobe.allocEn[1]   = pick1Ok && free1Ok;
    strobe.allocRs[0]   = free0;
    strobe.allocRs[1]   = free1;
    strobe.allocCand[0] = pick0;
    strobe.allocCand[1] = pick1;
    candTake            = '0;
    for (int c = 0; c < NUM_CAND; c++) begin
      if (strobe.allocEn[0] && pick0 == IDX_W'(c)) begin
        candTake[c]    = 1'b1;
        strobe.capJ[0] = candJPend[c];
        strobe.capK[0] = candKPend[c];
      end
      if (strobe.allocEn[1] && pick1 == IDX_W'(c)) begin
        candTake[c]    = 1'b1;
        strobe.capJ[1] = candJPend[c];
        strobe.capK[1] = candKPend[c];
      end
    end

    taken = '0;
    found = 1'b0; best = '0; bestAge = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      found = 1'b0; best = '0; bestAge = '0;
      if (unitAccept[u]) begin
        for (int r = 0; r < NUM_RS; r++)
          if (rsBusy[r] && !taken[r] && rsCls[r] == unitClass(u) &&
              (!found || rsAge[r] < bestAge)) begin
            found = 1'b1; best = IDX_W'(r); bestAge = rsAge[r];
          end
      end
      if (found) begin
        strobe.issueEn[u] = 1'b1;
        strobe.issueRs[u] = best;
        for (int r = 0; r < NUM_RS; r++)
          if (best == IDX_W'(r)) taken[r] = 1'b1;
      end
    end
  end

  // result bus arbitration, oldest waiting result wins
  logic [TAG_W-1:0] winAge;

  always_comb begin
    grantValid = 1'b0;
    grantUnit  = '0;
    grantRob   = '0;
    winAge     = '0;
    unitGrant  = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (unitResValid[u] && (!grantValid || (unitResRob[u] - robHead) < winAge)) begin
        grantValid = 1'b1;
        grantUnit  = UNIT_W'(u);
        grantRob   = unitResRob[u];
        winAge     = unitResRob[u] - robHead;
      end
    for (int u = 0; u < NUM_UNITS; u++)
      unitGrant[u] = grantValid && grantUnit == UNIT_W'(u);
  end

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int NUM_RS   = 4,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 16,
  parameter int FN_W     = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  rsStrobeT                            strobe,
  input  logic [NUM_CAND-1:0][1:0]            candCls,
  input  logic [NUM_CAND-1:0][FN_W-1:0]       candFn,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candRob,
  input  logic [NUM_CAND-1:0][DATA_W-1:0]     candJVal,
  input  logic [NUM_CAND-1:0][DATA_W-1:0]     candKVal,
  input  logic [DATA_W-1:0]                   busValue,
  output logic [NUM_RS-1:0]                   rsBusy,
  output logic [NUM_RS-1:0][1:0]              rsCls,
  output logic [NUM_RS-1:0][TAG_W-1:0]        rsRob,
  output logic [NUM_UNITS-1:0][FN_W-1:0]      issueFn,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]    issueJ,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]    issueK,
  output logic [NUM_UNITS-1:0][TAG_W-1:0]     issueRob
);

  logic [NUM_RS-1:0][FN_W-1:0]   rsFn;
  logic [NUM_RS-1:0][DATA_W-1:0] rsVj, rsVk;
  logic [NUM_RS-1:0]             relMask;
  logic [1:0][1:0]               newCls;
  logic [1:0][FN_W-1:0]          newFn;
  logic [1:0][TAG_W-1:0]         newRob;
  logic [1:0][DATA_W-1:0]        newJ, newK;

  // operand capture: bus value replaces any operand that woke this cycle
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      newCls[s] = '0; newFn[s] = '0; newRob[s] = '0; newJ[s] = '0; newK[s] = '0;
      for (int c = 0; c < NUM_CAND; c++)
        if (strobe.allocCand[s] == IDX_W'(c)) begin
          newCls[s] = candCls[c];
          newFn[s]  = candFn[c];
          newRob[s] = candRob[c];
          newJ[s]   = strobe.capJ[s] ? busValue : candJVal[c];
          newK[s]   = strobe.capK[s] ? busValue : candKVal[c];
        end
    end
    relMask = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      for (int r = 0; r < NUM_RS; r++)
        if (strobe.issueEn[u] && strobe.issueRs[u] == IDX_W'(r)) relMask[r] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsBusy <= '0;
      rsCls  <= '0;
      rsFn   <= '0;
      rsRob  <= '0;
      rsVj   <= '0;
      rsVk   <= '0;
    end else begin
      for (int r = 0; r < NUM_RS; r++) begin
        if (relMask[r]) rsBusy[r] <= 1'b0;
        for (int s = 0; s < 2; s++)
          if (strobe.allocEn[s] && strobe.allocRs[s] == IDX_W'(r)) begin
            rsBusy[r] <= 1'b1;
            rsCls[r]  <= newCls[s];
            rsFn[r]   <= newFn[s];
            rsRob[r]  <= newRob[s];
            rsVj[r]   <= newJ[s];
            rsVk[r]   <= newK[s];
          end
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      issueFn[u] = '0; issueJ[u] = '0; issueK[u] = '0; issueRob[u] = '0;
      for (int r = 0; r < NUM_RS; r++)
        if (strobe.issueRs[u] == IDX_W'(r)) begin
          issueFn[u]  = rsFn[r];
          issueJ[u]   = rsVj[r];
          issueK[u]   = rsVk[r];
          issueRob[u] = rsRob[r];
        end
    end
  end

endmodule

// File: rtl/rs_dispatch.sv
module rs_dispatch
  import rs_pkg::*;
#(
  parameter int NUM_CAND  = 4,
  parameter int NUM_RS    = 4,
  parameter int ROB_DEPTH = 8,
  parameter int DATA_W    = 16,
  parameter int FN_W      = 4,
  parameter int LAT_INT   = 2,
  parameter int LAT_ADD   = 4,
  parameter int LAT_MUL   = 6,
  parameter int LAT_DIV   = 10,
  localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [TAG_W-1:0]                    robHead,
  input  logic [NUM_CAND-1:0]                 candValid,
  input  logic [NUM_CAND-1:0][1:0]            candCls,
  input  logic [NUM_CAND-1:0][FN_W-1:0]       candFn,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candRob,
  input  logic [NUM_CAND-1:0]                 candJPend,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candJTag,
  input  logic [NUM_CAND-1:0][DATA_W-1:0]     candJVal,
  input  logic [NUM_CAND-1:0]                 candKPend,
  input  logic [NUM_CAND-1:0][TAG_W-1:0]      candKTag,
  input  logic [NUM_CAND-1:0][DATA_W-1:0]     candKVal,
  input  logic                                busValid,
  input  logic [TAG_W-1:0]                    busTag,
  input  logic [DATA_W-1:0]                   busValue,
  output logic [NUM_CAND-1:0]                 candTake,
  output logic [NUM_RS-1:0]                   rsBusy,
  output logic [NUM_UNITS-1:0]                issueValid,
  output logic [NUM_UNITS-1:0][FN_W-1:0]      issueFn,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]    issueJ,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]    issueK,
  output logic [NUM_UNITS-1:0][TAG_W-1:0]     issueRob,
  output logic [NUM_UNITS-1:0]                unitBusy,
  output logic                                grantValid,
  output logic [UNIT_W-1:0]                   grantUnit,
  output logic [TAG_W-1:0]                    grantRob
);

  rsStrobeT                         strobe;
  logic [NUM_RS-1:0][1:0]           rsCls;
  logic [NUM_RS-1:0][TAG_W-1:0]     rsRob;
  logic [NUM_UNITS-1:0]             unitAccept, unitResValid, unitGrant;
  logic [NUM_UNITS-1:0][TAG_W-1:0]  unitResRob;

  assign issueValid = strobe.issueEn;
  assign unitBusy   = ~unitAccept;

  rs_ctrl #(.NUM_CAND(NUM_CAND), .NUM_RS(NUM_RS), .TAG_W(TAG_W)) ctrl_i (
    .robHead(robHead), .candValid(candValid), .candRob(candRob),
    .candJPend(candJPend), .candJTag(candJTag), .candKPend(candKPend), .candKTag(candKTag),
    .busValid(busValid), .busTag(busTag),
    .rsBusy(rsBusy), .rsCls(rsCls), .rsRob(rsRob),
    .unitAccept(unitAccept), .unitResValid(unitResValid), .unitResRob(unitResRob),
    .strobe(strobe), .candTake(candTake), .unitGrant(unitGrant),
    .grantValid(grantValid), .grantUnit(grantUnit), .grantRob(grantRob)
  );

  rs_datapath #(.NUM_CAND(NUM_CAND), .NUM_RS(NUM_RS), .TAG_W(TAG_W),
                .DATA_W(DATA_W), .FN_W(FN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .candCls(candCls), .candFn(candFn), .candRob(candRob),
    .candJVal(candJVal), .candKVal(candKVal), .busValue(busValue),
    .rsBusy(rsBusy), .rsCls(rsCls), .rsRob(rsRob),
    .issueFn(issueFn), .issueJ(issueJ), .issueK(issueK), .issueRob(issueRob)
  );

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int L = (u == UNIT_INT) ? LAT_INT :
                         (u < 3)         ? LAT_ADD :
                         (u == 3)        ? LAT_MUL : LAT_DIV;
      rs_unit #(.LAT(L), .PIPED(u != UNIT_DIV), .TAG_W(TAG_W)) unit_i (
        .clk(clk), .rstN(rstN),
        .issue(strobe.issueEn[u]), .issueRob(issueRob[u]),
        .grant(unitGrant[u]), .accept(unitAccept[u]),
        .resValid(unitResValid[u]), .resRob(unitResRob[u])
      );
    end
  endgenerate

endmodule

// File: rtl/rs_dispatch_checker.sv
module rs_dispatch_checker #(
  parameter int NUM_CAND = 4,
  parameter int NUM_RS   = 4,
  parameter int NUM_U    = 5,
  parameter int LAT_DIV  = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CAND-1:0] candValid,
  input logic [NUM_CAND-1:0] candTake,
  input logic [NUM_RS-1:0]   rsBusy,
  input logic [NUM_U-1:0]    issueValid,
  input logic [NUM_U-1:0]    unitBusy,
  input logic                grantValid,
  input logic [2:0]          grantUnit
);

  logic        divOcc;
  logic [15:0] divAge;
  logic        divGrant;

  assign divGrant = grantValid && grantUnit == 3'd4;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divOcc <= 1'b0;
      divAge <= '0;
    end else if (issueValid[4]) begin
      divOcc <= 1'b1;
      divAge <= 16'd1;
    end else if (divGrant) begin
      divOcc <= 1'b0;
      divAge <= '0;
    end else if (divOcc && divAge != 16'hFFFF) begin
      divAge <= divAge + 16'd1;
    end
  end

  assert_take_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(candTake) <= 2);

  assert_take_only_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (candTake & ~candValid) == '0);

  assert_div_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    issueValid[4] |-> !divOcc);

  assert_div_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    divGrant |-> (divOcc && divAge >= 16'(LAT_DIV)));

  generate
    for (genvar u = 0; u < NUM_U; u++) begin : g_u
      assert_issue_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
        issueValid[u] |-> !unitBusy[u]);
    end
    for (genvar r = 0; r < NUM_RS; r++) begin : g_r
      assert_fill_after_take_R5: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rsBusy[r]) |-> $past(|candTake));
    end
  endgenerate

endmodule

bind rs_dispatch rs_dispatch_checker #(
  .NUM_CAND(NUM_CAND), .NUM_RS(NUM_RS), .NUM_U(5), .LAT_DIV(LAT_DIV)
) chk_i (
  .clk(clk), .rstN(rstN), .candValid(candValid), .candTake(candTake),
  .rsBusy(rsBusy), .issueValid(issueValid), .unitBusy(unitBusy),
  .grantValid(grantValid), .grantUnit(grantUnit)
);

// File: tb/rs_dispatch_tb.sv
`timescale 1ns/1ps
module rs_dispatch_tb_top;

  logic clk = 1'b0;
  logic rstN;
  always #10 clk = ~clk;

  logic [2:0]        robHead;
  logic [3:0]        candValid, candJPend, candKPend, candTake, rsBusy;
  logic [3:0][1:0]   candCls;
  logic [3:0][3:0]   candFn;
  logic [3:0][2:0]   candRob, candJTag, candKTag;
  logic [3:0][15:0]  candJVal, candKVal;
  logic              busValid;
  logic [2:0]        busTag;
  logic [15:0]       busValue;
  logic [4:0]        issueValid, unitBusy;
  logic [4:0][3:0]   issueFn;
  logic [4:0][15:0]  issueJ, issueK;
  logic [4:0][2:0]   issueRob;
  logic              grantValid;
  logic [2:0]        grantUnit, grantRob;

  int nVec = 0;
  int nMis = 0;

  rs_dispatch dut_i (
    .clk(clk), .rstN(rstN), .robHead(robHead),
    .candValid(candValid), .candCls(candCls), .candFn(candFn), .candRob(candRob),
    .candJPend(candJPend), .candJTag(candJTag), .candJVal(candJVal),
    .candKPend(candKPend), .candKTag(candKTag), .candKVal(candKVal),
    .busValid(busValid), .busTag(busTag), .busValue(busValue),
    .candTake(candTake), .rsBusy(rsBusy), .issueValid(issueValid),
    .issueFn(issueFn), .issueJ(issueJ), .issueK(issueK), .issueRob(issueRob),
    .unitBusy(unitBusy), .grantValid(grantValid), .grantUnit(grantUnit), .grantRob(grantRob)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nMis++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearCands();
    candValid = '0; candJPend = '0; candKPend = '0;
    candCls = '0; candFn = '0; candRob = '0; candJTag = '0; candKTag = '0;
    candJVal = '0; candKVal = '0;
    busValid = 1'b0; busTag = '0; busValue = '0;
  endtask

  task automatic setCand(input int c, input logic [1:0] cls, input logic [2:0] rob,
                         input logic [15:0] j, input logic [15:0] k);
    candValid[c] = 1'b1; candCls[c] = cls; candFn[c] = 4'(c + 1);
    candRob[c] = rob; candJVal[c] = j; candKVal[c] = k;
    candJPend[c] = 1'b0; candKPend[c] = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nMis++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; robHead = '0;
    clearCands();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rsBusy", 32'(rsBusy), 0);
    chk("R1 issueValid", 32'(issueValid), 0);
    chk("R1 unitBusy", 32'(unitBusy), 0);
    chk("R1 grantValid", 32'(grantValid), 0);
    @(negedge clk);

    // R4 / R3: oldest-two selection sweep over head and ready mask (no edge consumes it)
    for (int h = 0; h < 8; h++) begin
      for (int m = 1; m < 16; m++) begin
        logic [3:0] expMask;
        int a0, a1, i0, i1;
        robHead = 3'(h);
        clearCands();
        for (int c = 0; c < 4; c++)
          if (m[c]) setCand(c, 2'd0, 3'((c * 5 + 3) % 8), 16'h0, 16'h0);
        a0 = 99; a1 = 99; i0 = -1; i1 = -1;
        for (int c = 0; c < 4; c++)
          if (m[c]) begin
            int age;
            age = ((c * 5 + 3) - h + 8) % 8;
            if (age < a0) begin a1 = a0; i1 = i0; a0 = age; i0 = c; end
            else if (age < a1) begin a1 = age; i1 = c; end
          end
        expMask = '0;
        if (i0 >= 0) expMask[i0] = 1'b1;
        if (i1 >= 0) expMask[i1] = 1'b1;
        #1;
        chk($sformatf("R4 R3 head %0d mask %0h", h, m), 32'(candTake), 32'(expMask));
        #1;
        clearCands();
        @(negedge clk);
      end
    end
    robHead = '0;

    // R2: same-cycle wakeup sweep over bus tag and valid
    for (int v = 0; v < 2; v++) begin
      for (int b = 0; b < 8; b++) begin
        clearCands();
        setCand(0, 2'd0, 3'd1, 16'h0, 16'h0);
        candJPend[0] = 1'b1; candJTag[0] = 3'd3;
        busValid = v[0]; busTag = 3'(b);
        #1;
        chk($sformatf("R2 wake v%0d tag%0d", v, b), 32'(candTake[0]), 32'((v == 1) && (b == 3)));
        #1;
        clearCands();
        @(negedge clk);
      end
    end

    // R2 capture, R5 timing, R7 integer latency
    setCand(0, 2'd0, 3'd2, 16'h1111, 16'h0022);
    candJPend[0] = 1'b1; candJTag[0] = 3'd6;
    busValid = 1'b1; busTag = 3'd6; busValue = 16'hBEEF;
    #1;
    chk("R2 take on bus hit", 32'(candTake), 32'h1);
    step(); clearCands(); #1;
    chk("R5 issue next cycle", 32'(issueValid[0]), 1);
    chk("R2 captured bus value", 32'(issueJ[0]), 32'hBEEF);
    chk("R5 operand k", 32'(issueK[0]), 32'h0022);
    chk("R5 issue rob", 32'(issueRob[0]), 2);
    chk("R5 station held", 32'(rsBusy), 32'h1);
    step(); #1;
    chk("R5 station freed", 32'(rsBusy), 0);
    chk("R7 no grant early", 32'(grantValid), 0);
    step(); #1;
    chk("R7 int grant", 32'(grantValid), 1);
    chk("R7 int grant unit", 32'(grantUnit), 0);
    chk("R7 int grant rob", 32'(grantRob), 2);
    repeat (3) step();

    // R6 both adders, R9 arbitration
    setCand(0, 2'd1, 3'd1, 16'h0A, 16'h0B);
    setCand(1, 2'd1, 3'd0, 16'h0C, 16'h0D);
    #1;
    chk("R6 take both adds", 32'(candTake), 32'h3);
    step(); clearCands(); #1;
    chk("R6 two adders issue", 32'(issueValid), 32'h06);
    chk("R6 older to adder 1", 32'(issueRob[1]), 0);
    chk("R6 younger to adder 2", 32'(issueRob[2]), 1);
    step(); #1;
    chk("R7 pipelined adder free", 32'(unitBusy[1]), 0);
    step(); step(); step(); #1;
    chk("R9 grant older add", 32'({grantValid, grantUnit, grantRob}), 32'({1'b1, 3'd1, 3'd0}));
    chk("R9 loser busy", 32'(unitBusy[2]), 1);
    step(); #1;
    chk("R9 grant second add", 32'({grantValid, grantUnit, grantRob}), 32'({1'b1, 3'd2, 3'd1}));
    repeat (3) step();

    // R8 divider stall, R3 free limit, R10 station waiting
    setCand(0, 2'd3, 3'd0, 16'h1, 16'h1);
    setCand(1, 2'd3, 3'd1, 16'h2, 16'h2);
    #1;
    chk("R3 two divs taken", 32'(candTake), 32'h3);
    step(); clearCands();
    setCand(0, 2'd3, 3'd2, 16'h3, 16'h3);
    setCand(1, 2'd3, 3'd3, 16'h4, 16'h4);
    #1;
    chk("R8 div issue", 32'(issueValid[4]), 1);
    chk("R8 div issue rob", 32'(issueRob[4]), 0);
    chk("R3 low stations used", 32'(rsBusy), 32'h3);
    chk("R3 two more taken", 32'(candTake), 32'h3);
    step(); clearCands();
    setCand(0, 2'd0, 3'd4, 16'h5, 16'h5);
    setCand(1, 2'd0, 3'd5, 16'h6, 16'h6);
    #1;
    chk("R3 one free station", 32'(rsBusy), 32'hE);
    chk("R3 only oldest taken", 32'(candTake), 32'h1);
    chk("R8 div busy", 32'(unitBusy[4]), 1);
    step(); clearCands(); #1;
    chk("R3 all stations full", 32'(rsBusy), 32'hF);
    chk("R5 int rob4 issues", 32'({issueValid[0], issueRob[0]}), 32'({1'b1, 3'd4}));
    for (int t = 3; t < 11; t++) begin
      chk($sformatf("R8 div held t%0d", t), 32'({unitBusy[4], issueValid[4]}), 32'h2);
      chk($sformatf("R10 div stations wait t%0d", t), 32'(rsBusy[3:1]), 32'h7);
      step(); #1;
    end
    chk("R7 div grant", 32'({grantValid, grantUnit, grantRob}), 32'({1'b1, 3'd4, 3'd0}));
    step(); #1;
    chk("R8 next div issues", 32'({issueValid[4], issueRob[4]}), 32'({1'b1, 3'd1}));
    repeat (40) step();

    summary();
    $finish;
  end

endmodule